// File: doc/BRIEF.md
# CAN Identifier Acceptance Mask Filter

This block decides whether a CAN frame that reaches the catch-all receive object should be kept. Software programs a reference identifier and a per-bit significance mask through a small register write port. It also selects whether the filter works on 11-bit standard identifiers or on 29-bit extended identifiers. Each arriving identifier, together with its IDE flag, enters on a valid/ready stream. One clock later the block returns a single-bit verdict on a second valid/ready stream.

A mask bit at 1 means the identifier bit at that position must equal the reference bit. A mask bit at 0 means that position is not compared. After reset the mask is all zeros, so every frame of the configured kind is accepted until software narrows the filter.

Back-pressure works as follows. An identifier is taken on a clock edge where `id_valid` and `id_ready` are both high. `id_ready` is high whenever the result slot is empty or is being drained in the same cycle. A presented result holds its value until `res_ready` is seen high.

Top module: `can_id_acceptance_filter`

## Requirements
- R1: A mask bit of 0 lets the identifier bit at that position take either value without affecting the verdict.
- R2: A mask bit of 1 rejects the frame when the identifier bit at that position differs from the reference bit.
- R3: Register layout, shared by mask and reference:
  - The high word holds identifier bits 28..13, with bit 15 of the word carrying identifier bit 28.
  - The low word holds identifier bits 12..0 in word bits 15..3; word bits 2..0 are ignored.
  - Each word is written whole, 16 bits at once.
- R4: In standard mode only identifier bits 28..18 are compared. Identifier bits 17..0 and mask bits 17..0 have no effect on the verdict.
- R5: In extended mode all 29 identifier bits take part in the compare.
- R6: A frame whose IDE flag (1 = extended) differs from the configured mode is rejected, whatever the mask.
- R7: After reset the mask and reference are zero and the mode is standard, so every standard frame is accepted.
- R8: The verdict appears on `res_valid`/`res_accept` in the cycle after the clock edge that accepts the identifier.
- R9: While `res_valid` is high and `res_ready` is low, `res_accept` holds its value and `id_ready` is low.
- R10: The config address map is:
  - 0: mask high word
  - 1: mask low word
  - 2: reference high word
  - 3: reference low word
  - 4: mode, where bit 0 at 1 selects extended mode
  
  Writes to addresses 5 to 7 change nothing, and a write takes effect for identifiers accepted on later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select (see R10) |
| cfg_wdata | input | 16 | Register write data |
| id_valid | input | 1 | Identifier present |
| id_ready | output | 1 | Filter can take an identifier |
| id_value | input | 29 | Identifier; bit 28 is the first bit on the wire, and a standard identifier sits in bits 28..18 |
| id_ext | input | 1 | IDE flag of the frame, 1 = extended |
| res_valid | output | 1 | Verdict present |
| res_ready | input | 1 | Consumer takes the verdict |
| res_accept | output | 1 | 1 = frame passes the filter |

## Verification
The assertions assume the following about the inputs:
- `rst_n` is held low across at least one clock edge.
- `cfg_wdata` and `cfg_addr` are stable whenever `cfg_we` is sampled.
- The consumer keeps to the valid/ready rule, so a result is never assumed gone before `res_ready` is seen.

The stimulus keeps within these assumptions in three ways. It drives every input on the falling clock edge only. It never changes configuration while an identifier is in flight. It holds `res_ready` low only in the dedicated back-pressure phase.

The sweep walks a single significant mask bit across all 29 positions in both modes. At each position it flips only that identifier bit and also a neighbouring bit, so the verdict depends on one position at a time.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  typedef enum logic [2:0] {
    CFG_MASK_HI = 3'd0,
    CFG_MASK_LO = 3'd1,
    CFG_REF_HI  = 3'd2,
    CFG_REF_LO  = 3'd3,
    CFG_MODE    = 3'd4
  } cfg_addr_e;
endpackage

// File: rtl/can_filt_regs.sv
module can_filt_regs
  import can_filt_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ID_W   = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [ID_W-1:0]   mask_id,
  output logic [ID_W-1:0]   ref_id,
  output logic              ext_mode
);
  localparam int LO_W = ID_W - WORD_W;

  logic [ID_W-1:0] bank [2];

  // bank 0 = mask (addresses 0/1), bank 1 = reference (addresses 2/3)
  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam logic [2:0] HI_A = 3'(2 * b);
    localparam logic [2:0] LO_A = 3'(2 * b + 1);
    logic [WORD_W-1:0] hi_q;
    logic [LO_W-1:0]   lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q <= '0;
        lo_q <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == HI_A) hi_q <= cfg_wdata;
        if (cfg_addr == LO_A) lo_q <= cfg_wdata[WORD_W-1 -: LO_W];
      end
    end

    assign bank[b] = {hi_q, lo_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               ext_mode <= 1'b0;
    else if (cfg_we && cfg_addr == CFG_MODE)  ext_mode <= cfg_wdata[0];
  end

  assign mask_id = bank[0];
  assign ref_id  = bank[1];

  // R10
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == CFG_MODE) |=> (ext_mode == $past(cfg_wdata[0])));

  // R10
  unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr > CFG_MODE) |=> ($stable(mask_id) && $stable(ref_id) && $stable(ext_mode)));
endmodule

// File: rtl/can_filt_cmp.sv
module can_filt_cmp #(
  parameter int ID_W  = 29,
  parameter int STD_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] mask_id,
  input  logic [ID_W-1:0] ref_id,
  input  logic            ext_mode,
  input  logic [ID_W-1:0] id_value,
  input  logic            id_ext,
  output logic            hit
);
  localparam int LOW_W = ID_W - STD_W;
  localparam logic [ID_W-1:0] STD_KEEP = {{STD_W{1'b1}}, {LOW_W{1'b0}}};

  logic [ID_W-1:0] eff_mask;
  logic [ID_W-1:0] diff;
  logic            kind_ok;

  always_comb begin
    eff_mask = ext_mode ? mask_id : (mask_id & STD_KEEP);
    diff     = (id_value ^ ref_id) & eff_mask;
    kind_ok  = (id_ext == ext_mode);
    hit      = kind_ok && (diff == '0);
  end

  // R6
  kind_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_ext != ext_mode) |-> !hit);

  // R1
  open_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_id == '0 && id_ext == ext_mode) |-> hit);

  // R2
  exact_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_value == ref_id && id_ext == ext_mode) |-> hit);
endmodule

// File: rtl/can_filt_out.sv
module can_filt_out (
  input  logic clk,
  input  logic rst_n,
  input  logic id_valid,
  output logic id_ready,
  input  logic hit,
  output logic res_valid,
  input  logic res_ready,
  output logic res_accept
);
  logic take;

  assign id_ready = !res_valid || res_ready;
  assign take     = id_valid && id_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
    end else if (take) begin
      res_valid  <= 1'b1;
      res_accept <= hit;
    end else if (res_ready) begin
      res_valid  <= 1'b0;
    end
  end

  // R8
  result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && id_ready) |=> res_valid);

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_accept)));

  // R9
  stall_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !id_ready);
endmodule

// File: rtl/can_id_acceptance_filter.sv
module can_id_acceptance_filter #(
  parameter int WORD_W = 16,
  parameter int ID_W   = 29,
  parameter int STD_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              id_valid,
  output logic              id_ready,
  input  logic [ID_W-1:0]   id_value,
  input  logic              id_ext,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_accept
);
  logic [ID_W-1:0] mask_id;
  logic [ID_W-1:0] ref_id;
  logic            ext_mode;
  logic            hit;

  can_filt_regs #(.WORD_W(WORD_W), .ID_W(ID_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .mask_id(mask_id), .ref_id(ref_id), .ext_mode(ext_mode)
  );

  can_filt_cmp #(.ID_W(ID_W), .STD_W(STD_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .mask_id(mask_id), .ref_id(ref_id),
    .ext_mode(ext_mode), .id_value(id_value), .id_ext(id_ext), .hit(hit)
  );

  can_filt_out u_out (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_ready(id_ready),
    .hit(hit), .res_valid(res_valid), .res_ready(res_ready), .res_accept(res_accept)
  );

  // R7
  reset_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask_id == '0 && ref_id == '0 && !ext_mode));
endmodule

// File: tb/can_id_acceptance_filter_bench.sv
module can_id_acceptance_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        id_valid = 1'b0;
  logic        id_ready;
  logic [28:0] id_value = '0;
  logic        id_ext = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_accept;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // model state, written only by the bench
  logic [31:0] m_mask = '0;
  logic [31:0] m_ref  = '0;
  logic        m_ext  = 1'b0;

  always #10 clk = ~clk;

  can_id_acceptance_filter u_can_id_acceptance_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .id_valid(id_valid), .id_ready(id_ready),
    .id_value(id_value), .id_ext(id_ext), .res_valid(res_valid),
    .res_ready(res_ready), .res_accept(res_accept)
  );

  function automatic logic expect_accept(logic [28:0] id, logic ide);
    if (ide != m_ext) return 1'b0;
    for (int i = 0; i < 29; i++) begin
      if (m_mask[i+3] && (m_ext || i >= 18) && (id[i] != m_ref[i+3])) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic check(string req, logic actual, logic expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, actual, expected);
    end
  endtask

  task automatic cfg_write(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_mask(logic [31:0] v);
    cfg_write(3'd0, v[31:16]); cfg_write(3'd1, v[15:0]); m_mask = v;
  endtask

  task automatic set_ref(logic [31:0] v);
    cfg_write(3'd2, v[31:16]); cfg_write(3'd3, v[15:0]); m_ref = v;
  endtask

  task automatic set_mode(logic e);
    cfg_write(3'd4, {15'd0, e}); m_ext = e;
  endtask

  task automatic send(string req, logic [28:0] id, logic ide);
    @(negedge clk);
    id_valid = 1'b1; id_value = id; id_ext = ide;
    @(negedge clk);
    id_valid = 1'b0;
    check({req, " valid"}, res_valid, 1'b1);
    check(req, res_accept, expect_accept(id, ide));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [28:0] lfsr;
    logic [28:0] base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: reset state
    check("R7 res_valid idle", res_valid, 1'b0);
    check("R7 id_ready idle", id_ready, 1'b1);
    send("R7 open after reset", 29'h1ABC_DEF0, 1'b0);
    send("R7 open after reset b", 29'h0000_0000, 1'b0);
    send("R6 extended rejected in std mode", 29'h0123_4567, 1'b1);

    // R10: unused addresses change nothing
    cfg_write(3'd5, 16'hFFFF); cfg_write(3'd6, 16'hFFFF); cfg_write(3'd7, 16'hFFFF);
    send("R10 unused addr no effect", 29'h1555_5555, 1'b0);

    // R1 R2 R4 R5 R3: walk one significant bit across all positions in both modes
    base = 29'h0A5C_3E71;
    for (int e = 0; e < 2; e++) begin
      set_mode(e[0]);
      set_ref({base, 3'b101});
      for (int p = 0; p < 29; p++) begin
        set_mask(32'(1) << (p + 3));
        send("R2 R3 R4 R5 flip significant", base ^ (29'(1) << p), e[0]);
        send("R1 flip other bit", base ^ (29'(1) << ((p + 1) % 29)), e[0]);
        send("R2 exact ref", base, e[0]);
      end
    end

    // R4 R5 R6: pseudo-random sweep with full masks in both modes
    lfsr = 29'h13579BD;
    for (int e = 0; e < 2; e++) begin
      set_mode(e[0]);
      set_mask({lfsr, 3'b111});
      set_ref({lfsr ^ 29'h0F0F0F0, 3'b000});
      for (int k = 0; k < 40; k++) begin
        lfsr = {lfsr[27:0], lfsr[28] ^ lfsr[26]};
        send("R4 R5 sweep", (k % 3 == 0) ? (m_ref[31:3] ^ (lfsr & 29'h0003FFFF)) : lfsr, e[0]);
        send("R6 kind mismatch", lfsr, ~e[0]);
      end
    end

    // R8 R9: back-pressure
    set_mode(1'b0);
    set_mask(32'hFFE0_0000);
    set_ref(32'h0000_0000);
    res_ready = 1'b0;
    @(negedge clk);
    id_valid = 1'b1; id_value = 29'h0003_FFFF; id_ext = 1'b0;
    @(negedge clk);
    check("R8 first result valid", res_valid, 1'b1);
    check("R8 first verdict", res_accept, 1'b1);
    id_value = 29'h1000_0000;
    repeat (3) begin
      @(negedge clk);
      check("R9 held valid", res_valid, 1'b1);
      check("R9 held verdict", res_accept, 1'b1);
      check("R9 input stalled", id_ready, 1'b0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    id_valid = 1'b0;
    check("R9 second valid", res_valid, 1'b1);
    check("R9 second verdict", res_accept, 1'b0);
    @(negedge clk);
    check("R8 drained", res_valid, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule